// File: doc/BRIEF.md
# ARINC 429 Transmit Serializer

This block turns queued 32-bit words into a bipolar return-to-zero serial stream. A host writes whole words into a 32-entry transmit queue. While transmit is enabled, the block takes the oldest word into a shift register and sends it least significant bit first. Each bit is a data half followed by a null half. A fixed null gap separates one word from the next. The output is a two-wire code (A,B) for a line driver that sits outside this block.

Bit 32 can be sent as a data bit or replaced by a generated parity bit, which can be odd or even. Two rates are available, selected by a speed input. A ready flag tells the host that every queued word has gone out. A self-test tap copies the serial code to two receiver-side outputs: the first copy is unchanged, and the second carries the opposite data. A separate force input holds the line outputs at null. The active-low reset acts at once. It stops any word in flight and empties the queue. The configuration inputs are not affected by reset.

Top module: `a429_tx_serializer`

## Requirements
- R1: While `rstN` is low, and right after it is released, `txReady`=1, `fifoHalf`=0, `fifoFull`=0, and all line and loopback outputs are 0. Driving `rstN` low in the middle of a word forces the line to null at once and discards every queued word.
- R2: The queue holds up to 32 words. A write while `fifoFull`=1 is dropped and is never transmitted.
- R3: `fifoHalf` is 1 when 16 or more words are queued. `fifoFull` is 1 when 32 words are queued.
- R4: Word bit 0 (ARINC bit 1) goes out first and bit 31 goes out last. The line code is (lineA,lineB) = (1,0) for a one, (0,1) for a zero and (0,0) for null. (1,1) never appears.
- R5: When `lowSpeed`=0, each bit holds its data level for 5 clocks and is then null for 5 clocks. After the null half of bit 32, the line stays null for exactly 40 more clocks before the first data half of the next queued word.
- R6: When `lowSpeed`=1, the halves are 40 clocks each and the extra gap after a word is 320 clocks.
- R7: When the block is idle with a word queued, the first data half appears on the line in the cycle after the first clock edge that samples `txEnable`=1.
- R8: When `parityEn`=1 and `paritySense`=0, bit 32 on the line makes the count of ones in all 32 transmitted bits odd.
- R9: When `parityEn`=1 and `paritySense`=1, bit 32 makes that count even.
- R10: When `parityEn`=0, bit 32 on the line equals bit 31 of the written word.
- R11: `txReady` is 1 only when the queue is empty and no word or word gap is in progress. It stays 0 through the 40-clock gap after the last word and rises on the next clock.
- R12: When `selfTestN`=0, `loopRx1A`/`loopRx1B` carry the serial code unchanged, and `loopRx2A`/`loopRx2B` carry it with its data inverted (A and B swapped). When `selfTestN`=1, all four loopback outputs are 0.
- R13: `testForceNull`=1 holds `lineA` and `lineB` at 0 and does not affect the loopback outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-timing clock |
| rstN | input | 1 | Asynchronous active-low master reset |
| wrEn | input | 1 | Write one word into the queue |
| wrData | input | 32 | Word to queue; bit 0 is ARINC bit 1 |
| txEnable | input | 1 | Allows words to be taken from the queue and sent |
| lowSpeed | input | 1 | 1 selects the slow rate, 0 the fast rate |
| parityEn | input | 1 | 1 replaces bit 32 with generated parity |
| paritySense | input | 1 | Parity sense: 0 odd, 1 even |
| selfTestN | input | 1 | 0 enables the loopback tap |
| testForceNull | input | 1 | 1 forces the line outputs to null |
| lineA | output | 1 | Line code, A wire |
| lineB | output | 1 | Line code, B wire |
| loopRx1A | output | 1 | Loopback to first receiver, A |
| loopRx1B | output | 1 | Loopback to first receiver, B |
| loopRx2A | output | 1 | Inverted loopback to second receiver, A |
| loopRx2B | output | 1 | Inverted loopback to second receiver, B |
| txReady | output | 1 | All queued words have been sent |
| fifoHalf | output | 1 | 16 or more words queued |
| fifoFull | output | 1 | 32 words queued |

## Verification
Words are decoded from the line one sample per clock. Each data half and null half is checked for its exact length at both rates, and each null run between words is measured.

The test words are chosen so the three parity settings give different bit 32 values:
- Words with an even and an odd count of ones in bits 0–30 separate odd parity from even parity.
- Words with bit 31 set and cleared show whether parity bypass passes the written bit through.

A 33-write burst confirms that the flags change at the 16th and 32nd entries and that the extra word is never sent. Three further runs cover the remaining behaviour:
- a run with the loopback tap on and the line forced null, which shows that the tap and the force act independently;
- a run with the tap off;
- a reset in the middle of a word.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // take queue head into the shift register
    logic shift;  // advance to next bit
    logic drive;  // data half of a bit is on the line
  } txStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_NULL = 2'd2,
    ST_GAP  = 2'd3
  } txState_t;

endpackage

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full,
  output logic             halfFull
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign halfFull = (count >= CW'(DEPTH / 2));
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R2
  AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (count == $past(count))); // R2
  AST_HALF_BEFORE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    full |-> halfFull); // R3

endmodule

// File: rtl/a429_tx_ctrl.sv
module a429_tx_ctrl
  import a429_tx_pkg::*;
#(
  parameter int BITS    = 32,
  parameter int HS_HALF = 5,
  parameter int HS_GAP  = 40,
  parameter int LS_HALF = 40,
  parameter int LS_GAP  = 320
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEnable,
  input  logic      lowSpeed,
  input  logic      fifoEmpty,
  output txStrobe_t strobes,
  output logic      txReady
);

  localparam int MAX_HALF = (LS_HALF > HS_HALF) ? LS_HALF : HS_HALF;
  localparam int MAX_GAP  = (LS_GAP > HS_GAP) ? LS_GAP : HS_GAP;
  localparam int MAX_CNT  = (MAX_GAP > MAX_HALF) ? MAX_GAP : MAX_HALF;
  localparam int TW       = $clog2(MAX_CNT + 1);
  localparam int BW       = $clog2(BITS);

  txState_t      state, stateNext;
  logic [TW-1:0] timer, timerNext;
  logic [BW-1:0] bitIdx, bitIdxNext;
  logic [TW-1:0] halfLim, gapLim;
  logic          halfEnd, gapEnd, startOk;

  assign halfLim = lowSpeed ? TW'(LS_HALF - 1) : TW'(HS_HALF - 1);
  assign gapLim  = lowSpeed ? TW'(LS_GAP - 1)  : TW'(HS_GAP - 1);
  assign halfEnd = (timer >= halfLim);
  assign gapEnd  = (timer >= gapLim);
  assign startOk = txEnable && !fifoEmpty;

  always_comb begin
    stateNext     = state;
    timerNext     = timer + 1'b1;
    bitIdxNext    = bitIdx;
    strobes.load  = 1'b0;
    strobes.shift = 1'b0;
    strobes.drive = (state == ST_DATA);
    case (state)
      ST_IDLE: begin
        timerNext = '0;
        if (startOk) begin
          strobes.load = 1'b1;
          stateNext    = ST_DATA;
          bitIdxNext   = '0;
        end
      end
      ST_DATA: begin
        if (halfEnd) begin
          stateNext = ST_NULL;
          timerNext = '0;
        end
      end
      ST_NULL: begin
        if (halfEnd) begin
          timerNext = '0;
          if (bitIdx == BW'(BITS - 1)) begin
            stateNext = ST_GAP;
          end else begin
            strobes.shift = 1'b1;
            bitIdxNext    = bitIdx + 1'b1;
            stateNext     = ST_DATA;
          end
        end
      end
      ST_GAP: begin
        if (gapEnd) begin
          timerNext = '0;
          if (startOk) begin
            strobes.load = 1'b1;
            bitIdxNext   = '0;
            stateNext    = ST_DATA;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      timer  <= '0;
      bitIdx <= '0;
    end else begin
      state  <= stateNext;
      timer  <= timerNext;
      bitIdx <= bitIdxNext;
    end
  end

  assign txReady = (state == ST_IDLE) && fifoEmpty;

  AST_LOAD_HAS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |-> !fifoEmpty); // R2
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TW'(MAX_CNT)); // R5
  AST_LOAD_STARTS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> strobes.drive); // R7

endmodule

// File: rtl/a429_tx_datapath.sv
module a429_tx_datapath
  import a429_tx_pkg::*;
#(
  parameter int BITS = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  txStrobe_t       strobes,
  input  logic [BITS-1:0] headWord,
  input  logic            parityEn,
  input  logic            paritySense,
  output logic            rawA,
  output logic            rawB
);

  logic [BITS-1:0] shiftReg;
  logic            onesOdd, lastBit;

  assign onesOdd = ^headWord[BITS-2:0];
  assign lastBit = parityEn ? (onesOdd ^ ~paritySense) : headWord[BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.load) begin
      shiftReg <= {lastBit, headWord[BITS-2:0]};
    end else if (strobes.shift) begin
      shiftReg <= {1'b0, shiftReg[BITS-1:1]};
    end
  end

  assign rawA = strobes.drive && shiftReg[0];
  assign rawB = strobes.drive && !shiftReg[0];

  AST_LINE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rawA && rawB)); // R4
  AST_PARITY_ODD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && parityEn && !paritySense) |=> (^shiftReg == 1'b1)); // R8

endmodule

// File: rtl/a429_tx_serializer.sv
module a429_tx_serializer
  import a429_tx_pkg::*;
#(
  parameter int BITS    = 32,
  parameter int DEPTH   = 32,
  parameter int HS_HALF = 5,
  parameter int HS_GAP  = 40,
  parameter int LS_HALF = 40,
  parameter int LS_GAP  = 320
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [BITS-1:0] wrData,
  input  logic            txEnable,
  input  logic            lowSpeed,
  input  logic            parityEn,
  input  logic            paritySense,
  input  logic            selfTestN,
  input  logic            testForceNull,
  output logic            lineA,
  output logic            lineB,
  output logic            loopRx1A,
  output logic            loopRx1B,
  output logic            loopRx2A,
  output logic            loopRx2B,
  output logic            txReady,
  output logic            fifoHalf,
  output logic            fifoFull
);

  txStrobe_t       strobes;
  logic [BITS-1:0] headWord;
  logic            fifoEmpty;
  logic            rawA, rawB;

  a429_tx_fifo #(.WIDTH(BITS), .DEPTH(DEPTH)) uFifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (wrEn),
    .pushData (wrData),
    .pop      (strobes.load),
    .headData (headWord),
    .empty    (fifoEmpty),
    .full     (fifoFull),
    .halfFull (fifoHalf)
  );

  a429_tx_ctrl #(
    .BITS(BITS), .HS_HALF(HS_HALF), .HS_GAP(HS_GAP),
    .LS_HALF(LS_HALF), .LS_GAP(LS_GAP)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .txEnable  (txEnable),
    .lowSpeed  (lowSpeed),
    .fifoEmpty (fifoEmpty),
    .strobes   (strobes),
    .txReady   (txReady)
  );

  a429_tx_datapath #(.BITS(BITS)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .headWord    (headWord),
    .parityEn    (parityEn),
    .paritySense (paritySense),
    .rawA        (rawA),
    .rawB        (rawB)
  );

  assign lineA    = rawA && !testForceNull;
  assign lineB    = rawB && !testForceNull;
  assign loopRx1A = rawA && !selfTestN;
  assign loopRx1B = rawB && !selfTestN;
  assign loopRx2A = rawB && !selfTestN;
  assign loopRx2B = rawA && !selfTestN;

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (!lineA && !lineB)); // R11
  AST_LOOP_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    !selfTestN |-> (loopRx2A == loopRx1B && loopRx2B == loopRx1A)); // R12

endmodule

// File: tb/a429_tx_serializer_test.sv
module a429_tx_serializer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        txEnable = 1'b0, lowSpeed = 1'b0, parityEn = 1'b1, paritySense = 1'b0;
  logic        selfTestN = 1'b1, testForceNull = 1'b0;
  logic        lineA, lineB, loopRx1A, loopRx1B, loopRx2A, loopRx2B;
  logic        txReady, fifoHalf, fifoFull;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  a429_tx_serializer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .txEnable(txEnable),
    .lowSpeed(lowSpeed), .parityEn(parityEn), .paritySense(paritySense),
    .selfTestN(selfTestN), .testForceNull(testForceNull),
    .lineA(lineA), .lineB(lineB), .loopRx1A(loopRx1A), .loopRx1B(loopRx1B),
    .loopRx2A(loopRx2A), .loopRx2B(loopRx2B),
    .txReady(txReady), .fifoHalf(fifoHalf), .fifoFull(fifoFull)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input logic [31:0] w, input logic pe, input logic ps);
    logic p;
    if (!pe) return w;
    p = (^w[30:0]) ? ps : ~ps;
    return {p, w[30:0]};
  endfunction

  task automatic pushWord(input logic [31:0] w);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = w;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Starts at a negedge; decodes one word from the line, counting timing errors
  task automatic capture(input int half, output logic [31:0] w, output int badT, output bit found);
    int waitN;
    logic lvA;
    waitN = 0; badT = 0; w = '0; found = 0;
    while (!(lineA || lineB)) begin
      if (waitN > 5000) return;
      @(negedge clk);
      waitN++;
    end
    found = 1;
    for (int b = 0; b < 32; b++) begin
      lvA = lineA;
      w[b] = lineA;
      for (int k = 0; k < half; k++) begin
        if (k > 0) @(negedge clk);
        if (lineA !== lvA || lineB !== ~lvA) badT++;
      end
      for (int k = 0; k < half; k++) begin
        @(negedge clk);
        if (lineA || lineB) badT++;
      end
      if (b < 31) @(negedge clk);
    end
  endtask

  task automatic nullRun(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      if (lineA || lineB) return;
      n++;
    end
  endtask

  task automatic testReset();
    chk("R1 txReady", {31'd0, txReady}, 32'd1);
    chk("R1 fifoHalf/Full", {30'd0, fifoHalf, fifoFull}, 32'd0);
    chk("R1 line", {30'd0, lineA, lineB}, 32'd0);
    chk("R1 loop", {28'd0, loopRx1A, loopRx1B, loopRx2A, loopRx2B}, 32'd0);
  endtask

  task automatic testParityHs();
    logic [31:0] words [4];
    logic        pe [4], ps [4];
    logic [31:0] got;
    int bad; bit found;
    words[0] = 32'h0000_0003; pe[0] = 1; ps[0] = 0;  // even ones, odd parity
    words[1] = 32'h0000_0007; pe[1] = 1; ps[1] = 1;  // odd ones, even parity
    words[2] = 32'h8123_4567; pe[2] = 0; ps[2] = 0;  // bypass, bit31=1
    words[3] = 32'h1234_ABCD; pe[3] = 0; ps[3] = 1;  // bypass, bit31=0
    lowSpeed = 0;
    for (int i = 0; i < 4; i++) begin
      parityEn = pe[i]; paritySense = ps[i];
      pushWord(words[i]);
      txEnable = 1'b1;
      @(negedge clk);
      chk("R7 first data one cycle after enable", {31'd0, lineA | lineB}, 32'd1);
      chk("R11 ready low while sending", {31'd0, txReady}, 32'd0);
      capture(5, got, bad, found);
      txEnable = 1'b0;
      chk("R5 high-speed half timing", bad, 0);
      chk(i < 2 ? (i == 0 ? "R8 odd parity word" : "R9 even parity word")
                : "R10 parity bypass word", got, expWord(words[i], pe[i], ps[i]));
      chk("R4 bit order low bits", {24'd0, got[7:0]}, {24'd0, words[i][7:0]});
      repeat (40) @(negedge clk);
      chk("R11 ready low through gap", {31'd0, txReady}, 32'd0);
      @(negedge clk);
      chk("R11 ready after gap", {31'd0, txReady}, 32'd1);
    end
    parityEn = 1; paritySense = 0;
  endtask

  task automatic testGap(input bit slow);
    logic [31:0] got;
    int bad, n, half, gap; bit found;
    half = slow ? 40 : 5;
    gap  = slow ? 320 : 40;
    lowSpeed = slow;
    pushWord(32'h2AAA_5555);
    pushWord(32'h6F0F_F0F0);
    txEnable = 1'b1;
    @(negedge clk);
    capture(half, got, bad, found);
    chk(slow ? "R6 low-speed half timing w0" : "R5 half timing w0", bad, 0);
    chk(slow ? "R6 low-speed word0" : "R5 word0", got, expWord(32'h2AAA_5555, 1, 0));
    nullRun(1000, n);
    chk(slow ? "R6 low-speed word gap" : "R5 word gap", n, gap);
    capture(half, got, bad, found);
    chk(slow ? "R6 low-speed half timing w1" : "R5 half timing w1", bad, 0);
    chk(slow ? "R6 low-speed word1" : "R5 word1", got, expWord(32'h6F0F_F0F0, 1, 0));
    txEnable = 1'b0;
    repeat (gap + 2) @(negedge clk);
    lowSpeed = 0;
  endtask

  task automatic testFull();
    logic [31:0] got;
    int bad, n, errs; bit found;
    parityEn = 0;
    errs = 0;
    for (int i = 0; i < 33; i++) begin
      pushWord(32'hA500_0000 ^ (i * 32'h0101_0101) ^ i);
      if (i == 14) chk("R3 half clear at 15", {31'd0, fifoHalf}, 32'd0);
      if (i == 15) chk("R3 half set at 16", {31'd0, fifoHalf}, 32'd1);
      if (i == 30) chk("R3 full clear at 31", {31'd0, fifoFull}, 32'd0);
      if (i == 31) chk("R3 full set at 32", {31'd0, fifoFull}, 32'd1);
    end
    txEnable = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      capture(5, got, bad, found);
      if (got !== (32'hA500_0000 ^ (i * 32'h0101_0101) ^ i) || bad != 0) errs++;
      if (i < 31) nullRun(1000, n);
    end
    chk("R2 32 queued words sent in order", errs, 0);
    nullRun(500, n);
    chk("R2 write beyond full never sent", n, 500);
    chk("R11 ready after drain", {31'd0, txReady}, 32'd1);
    txEnable = 1'b0;
    parityEn = 1;
  endtask

  task automatic testLoop();
    int lineAct, mism, rx1Act, rx1Ones, loopAct;
    logic [31:0] w;
    w = 32'h0F0F_0011;
    selfTestN = 0; testForceNull = 1;
    lineAct = 0; mism = 0; rx1Act = 0; rx1Ones = 0;
    pushWord(w);
    txEnable = 1'b1;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (lineA || lineB) lineAct++;
      if (loopRx2A !== loopRx1B || loopRx2B !== loopRx1A) mism++;
      if (loopRx1A || loopRx1B) rx1Act++;
      if (loopRx1A) rx1Ones++;
    end
    txEnable = 1'b0;
    chk("R13 forced null line", lineAct, 0);
    chk("R12 rx2 inverted copy", mism, 0);
    chk("R12 rx1 data cycles", rx1Act, 160);
    chk("R12 rx1 one cycles", rx1Ones, 5 * $countones(expWord(w, 1, 0)));
    selfTestN = 1; testForceNull = 0;
    lineAct = 0; loopAct = 0;
    pushWord(w);
    txEnable = 1'b1;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (lineA || lineB) lineAct++;
      if (loopRx1A || loopRx1B || loopRx2A || loopRx2B) loopAct++;
    end
    txEnable = 1'b0;
    chk("R12 tap off quiet", loopAct, 0);
    chk("R13 line active when not forced", lineAct, 160);
  endtask

  task automatic testMidReset();
    int act;
    for (int i = 0; i < 20; i++) pushWord(32'hFFFF_0000 + i);
    txEnable = 1'b1;
    repeat (30) @(negedge clk);
    chk("R3 half with 19 queued", {31'd0, fifoHalf}, 32'd1);
    rstN = 1'b0;
    #1;
    chk("R1 line null at reset", {30'd0, lineA, lineB}, 32'd0);
    chk("R1 ready at reset", {31'd0, txReady}, 32'd1);
    chk("R1 half cleared", {31'd0, fifoHalf}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    act = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (lineA || lineB) act++;
    end
    chk("R1 queue emptied by reset", act, 0);
    txEnable = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testParityHs();
    testGap(0);
    testGap(1);
    testFull();
    testLoop();
    testMidReset();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule